// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

The controller gathers eight interrupt request lines into one interrupt output for a processor. A rising edge on a line records a request. The controller raises its interrupt output when a recorded request is not masked and outranks everything already in service. Line 0 has the highest rank and line 7 the lowest. The processor answers with an active-low acknowledge. In that cycle the winning request moves into the in-service register. On the next cycle the controller places an 8-bit vector on its output for one cycle. The vector is a programmable 5-bit base in the upper bits and the 3-bit line number in the lower bits. The processor uses this vector to index its table of handlers.

Two identical controllers can be chained to serve fifteen sources. A master with cascade enabled treats line 2 as a level-sensitive input, driven by the interrupt output of a slave. When line 2 wins an acknowledge, the master takes three actions:
- It pulls its cascade-acknowledge output low in the same cycle. This output feeds the slave's acknowledge input.
- It keeps its own vector output disabled, so the slave supplies the vector.
- It records line 2 as in service.

Software writes four registers through a simple write port: the mask, the vector base, an end-of-interrupt command and the cascade enable.

Top module: `pic_cascade`

## Requirements
- R1: A 0-to-1 change on a request line, seen at a clock edge, records a request. The request stays recorded until it is acknowledged. A line held high after its acknowledge records nothing new until it falls and rises again.
- R2: Writing address 0 loads the mask. Mask bit i set to 1 keeps line i from raising `int_o`, but a request recorded on line i is kept. Clearing bit i later lets that request raise `int_o`. After reset the mask is all ones.
- R3: `int_o` is high exactly when a recorded request exists that is unmasked and whose line number is lower than the lowest in-service line number. It is also high for such a request when nothing is in service.
- R4: When several requests qualify, the lowest-numbered line wins.
- R5: An acknowledge is `inta_ni` low at a clock edge while `int_o` is high. One cycle after it, `vec_oe_o` is high for one cycle and `vec_o` equals {base, line[2:0]}. The base is `wr_data_i[7:3]` from the last write to address 1, and is 0 after reset.
- R6: An acknowledge clears the winner's request and sets its in-service bit. While that bit is set, lines of equal or lower priority cannot raise `int_o`, but higher-priority lines can.
- R7: Any write to address 2 clears the lowest-numbered set in-service bit and leaves the other in-service bits unchanged.
- R8: Writing address 3 with `wr_data_i[0]`=1 enables cascade mode. In this mode line 2 is level-sensitive. When line 2 wins an acknowledge, `casc_ack_no` is low in that same cycle, `vec_oe_o` stays low, and line 2 goes in service.
- R9: `inta_ni` low while `int_o` is low changes nothing and produces no vector.
- R10: After reset, `int_o` is 0, `vec_oe_o` is 0 and `casc_ack_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines; line 2 serves as the cascade input when cascade is enabled |
| inta_ni | input | 1 | Acknowledge from the processor, or from the master's `casc_ack_no`; active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 mask, 1 base, 2 end of interrupt, 3 cascade enable |
| wr_data_i | input | 8 | Register write data |
| int_o | output | 1 | Interrupt request to the processor, or to the master's line 2 |
| casc_ack_no | output | 1 | Acknowledge passed to the slave, active low |
| vec_o | output | 8 | Vector of the last acknowledged line |
| vec_oe_o | output | 1 | Vector valid, a one-cycle pulse |

## Verification
A request recorded at a clock edge shows on `int_o` right after that edge. The bench therefore drives inputs just after a falling edge, lets one rising edge pass, and samples at the next falling edge. The vector and its enable come from registers loaded at the acknowledge edge. The bench compares them at the falling edge that follows that acknowledge edge, against a model stepped once per rising edge. `casc_ack_no` depends on the current state and inputs through logic alone, so the bench checks it shortly after it drives `inta_ni`, before the edge. The slave's vector shows on the same following falling edge as the master's would.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_BASE = 2'd1,
    REG_EOI  = 2'd2,
    REG_CASC = 2'd3
  } pic_reg_e;
endpackage

// File: rtl/pic_req_latch.sv
`timescale 1ns/1ps
module pic_req_latch #(
  parameter int N         = 8,
  parameter int CASC_LINE = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic         casc_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] irq_q, irr_q, rise, casc_sel;

  assign casc_sel = casc_en_i ? (N'(1) << CASC_LINE) : '0;
  assign rise     = irq_i & ~irq_q;
  // cascade line follows the slave level; others are latched edges
  assign pend_o   = (irr_q & ~casc_sel) | (irq_i & casc_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      irr_q <= '0;
    end else begin
      irq_q <= irq_i;
      irr_q <= ((irr_q & ~clr_i) | rise) & ~casc_sel;
    end
  end

  // R1
  edge_latched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irr_q & $past(rise & ~casc_sel)) == $past(rise & ~casc_sel)));
endmodule

// File: rtl/pic_resolver.sv
`timescale 1ns/1ps
module pic_resolver #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     isr_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  logic [N-1:0] allow, cand;

  always_comb begin
    allow = '1;
    for (int i = N - 1; i >= 0; i--)
      if (isr_i[i]) allow = (N'(1) << i) - N'(1);
  end

  assign cand = pend_i & ~mask_i & allow;

  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (cand[i]) begin
        idx_o    = IDX_W'(i);
        onehot_o = N'(1) << i;
      end
  end

  assign valid_o = |cand;
endmodule

// File: rtl/pic_isr.sv
`timescale 1ns/1ps
module pic_isr #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         eoi_i,
  output logic [N-1:0] isr_o
);
  logic [N-1:0] isr_q, top_bit;

  assign top_bit = isr_q & (~isr_q + N'(1));
  assign isr_o   = isr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~(eoi_i ? top_bit : '0)) | set_i;
  end

  // R7
  eoi_clears_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !(|set_i) && (|isr_q)) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
endmodule

// File: rtl/pic_cascade.sv
`timescale 1ns/1ps
module pic_cascade
  import pic_pkg::*;
#(
  parameter int N         = 8,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     irq_i,
  input  logic             inta_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [VEC_W-1:0] wr_data_i,
  output logic             int_o,
  output logic             casc_ack_no,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_oe_o
);
  localparam int IDX_W  = $clog2(N);
  localparam int BASE_W = VEC_W - IDX_W;

  logic [N-1:0]      mask_q, pend, isr, win_oh, isr_set;
  logic [BASE_W-1:0] base_q;
  logic              casc_en_q, win_valid, win_casc, ack_fire, eoi;
  logic [IDX_W-1:0]  win_idx;
  logic [VEC_W-1:0]  vec_q;
  logic              vec_oe_q;
  pic_reg_e          reg_sel;

  assign reg_sel = pic_reg_e'(wr_addr_i);
  assign eoi     = wr_en_i && (reg_sel == REG_EOI);

  pic_req_latch #(.N(N), .CASC_LINE(CASC_LINE)) u_req (
    .clk_i, .rst_ni, .irq_i,
    .casc_en_i (casc_en_q),
    .clr_i     (isr_set),
    .pend_o    (pend)
  );

  pic_resolver #(.N(N), .IDX_W(IDX_W)) u_res (
    .pend_i   (pend),
    .mask_i   (mask_q),
    .isr_i    (isr),
    .valid_o  (win_valid),
    .idx_o    (win_idx),
    .onehot_o (win_oh)
  );

  pic_isr #(.N(N)) u_isr (
    .clk_i, .rst_ni,
    .set_i (isr_set),
    .eoi_i (eoi),
    .isr_o (isr)
  );

  assign ack_fire    = !inta_ni && win_valid;
  assign win_casc    = casc_en_q && (win_idx == IDX_W'(CASC_LINE));
  assign isr_set     = ack_fire ? win_oh : '0;
  assign casc_ack_no = !(ack_fire && win_casc);
  assign int_o       = win_valid;
  assign vec_o       = vec_q;
  assign vec_oe_o    = vec_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '1;
      base_q    <= '0;
      casc_en_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (reg_sel)
        REG_MASK: mask_q    <= wr_data_i[N-1:0];
        REG_BASE: base_q    <= wr_data_i[VEC_W-1:IDX_W];
        REG_CASC: casc_en_q <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q    <= '0;
      vec_oe_q <= 1'b0;
    end else begin
      vec_oe_q <= ack_fire && !win_casc;
      if (ack_fire) vec_q <= {base_q, win_idx};
    end
  end

  // R2
  mask_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (|(pend & ~mask_q)));
  // R5
  vec_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> $past(!inta_ni && int_o));
  // R6
  ack_to_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire |=> isr[$past(win_idx)]);
  // R8
  casc_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !casc_ack_no |=> !vec_oe_o);
  // R9
  no_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inta_ni && !int_o) |=> !vec_oe_o);
endmodule

// File: tb/tb_pic_cascade.sv
`timescale 1ns/1ps
module tb_pic_cascade;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] m_irq = '0, s_irq = '0, wr_data = '0, m_irq_in;
  logic [1:0] wr_addr = '0;
  logic       m_inta_n = 1'b1, m_wr = 1'b0, s_wr = 1'b0, casc_mode = 1'b0, done = 1'b0;
  logic       m_int, m_cack_n, m_voe, s_int, s_cack_n, s_voe;
  logic [7:0] m_vec, s_vec;
  int         errs = 0, checks = 0;

  logic [7:0] md_irr, md_isr, md_mask, md_prev, exp_vec;
  logic [4:0] md_base;
  logic       exp_oe;

  always #5 clk = ~clk;

  assign m_irq_in = casc_mode ? {m_irq[7:3], s_int, m_irq[1:0]} : m_irq;

  pic_cascade dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(m_irq_in), .inta_ni(m_inta_n),
    .wr_en_i(m_wr), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .int_o(m_int), .casc_ack_no(m_cack_n), .vec_o(m_vec), .vec_oe_o(m_voe));

  pic_cascade slv (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(s_irq), .inta_ni(m_cack_n),
    .wr_en_i(s_wr), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .int_o(s_int), .casc_ack_no(s_cack_n), .vec_o(s_vec), .vec_oe_o(s_voe));

  function automatic int win_of(logic [7:0] irr, logic [7:0] isr, logic [7:0] mask);
    int ceil = 8;
    for (int i = 7; i >= 0; i--) if (isr[i]) ceil = i;
    for (int i = 0; i < ceil; i++) if (irr[i] && !mask[i]) return i;
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    md_irr = '0; md_isr = '0; md_mask = 8'hFF; md_prev = '0; md_base = '0;
  endtask

  // drive one cycle on the master, advance the model, check at the next falling edge
  task automatic step(logic [7:0] irq, logic inta_n, logic wr, logic [1:0] a, logic [7:0] d);
    int w;
    logic [7:0] low;
    m_irq = irq; m_inta_n = inta_n; m_wr = wr; wr_addr = a; wr_data = d;
    w = win_of(md_irr, md_isr, md_mask);
    exp_oe = !inta_n && (w >= 0);
    exp_vec = {md_base, 3'(w)};
    @(posedge clk);
    low = md_isr & (~md_isr + 8'd1);
    if (wr && a == 2'd2) md_isr = md_isr & ~low;
    if (exp_oe) begin
      md_isr = md_isr | (8'd1 << w);
      md_irr = md_irr & ~(8'd1 << w);
    end
    md_irr = md_irr | (irq & ~md_prev);
    md_prev = irq;
    if (wr && a == 2'd0) md_mask = d;
    if (wr && a == 2'd1) md_base = d[7:3];
    @(negedge clk);
    chk("R3 int_o", 32'(m_int), 32'(win_of(md_irr, md_isr, md_mask) >= 0));
    chk("R5 vec_oe_o", 32'(m_voe), 32'(exp_oe));
    if (exp_oe) chk("R5 vec_o", 32'(m_vec), 32'(exp_vec));
  endtask

  // raw cycle without model (cascade section)
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    m_wr = 0; s_wr = 0; m_inta_n = 1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_irq = '0; s_irq = '0; m_inta_n = 1; m_wr = 0; s_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
  endtask

  initial begin
    #(10ns * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R10
    chk("R10 int_o", 32'(m_int), 0);
    chk("R10 vec_oe_o", 32'(m_voe), 0);
    chk("R10 casc_ack_no", 32'(m_cack_n), 1);

    // R2: masked after reset, request kept
    step(8'h01, 1, 0, 0, 0);
    chk("R2 masked int", 32'(m_int), 0);
    step(8'h01, 1, 1, 2'd0, 8'h00);
    chk("R2 unmask raises", 32'(m_int), 1);
    step(8'h01, 0, 0, 0, 0);
    chk("R5 vec base0", 32'(m_vec), 32'h00);
    // R9
    step(8'h01, 0, 0, 0, 0);
    chk("R9 no vector", 32'(m_voe), 0);
    // R1: level held, no re-latch after EOI
    step(8'h01, 1, 1, 2'd2, 0);
    chk("R1 no relatch", 32'(m_int), 0);
    step(8'h00, 1, 1, 2'd1, 8'h50);
    // R4
    step(8'h48, 1, 0, 0, 0);
    step(8'h48, 0, 0, 0, 0);
    chk("R4 vec line3", 32'(m_vec), 32'h53);
    chk("R6 lower blocked", 32'(m_int), 0);
    step(8'h4A, 1, 0, 0, 0);
    chk("R6 nesting", 32'(m_int), 1);
    step(8'h4A, 0, 0, 0, 0);
    chk("R5 vec line1", 32'(m_vec), 32'h51);
    step(8'h4A, 1, 1, 2'd2, 0);
    chk("R7 only top cleared", 32'(m_int), 0);
    step(8'h4A, 1, 1, 2'd2, 0);
    chk("R7 second eoi", 32'(m_int), 1);
    step(8'h00, 0, 0, 0, 0);
    chk("R4 vec line6", 32'(m_vec), 32'h56);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] irq_r;
      logic ia, wr;
      logic [1:0] a;
      irq_r = 8'($urandom);
      ia = ($urandom % 4) != 0;
      wr = ($urandom % 6) == 0;
      a  = 2'($urandom % 3);
      step(irq_r, ia, wr, a, (a == 2'd0) ? 8'($urandom & 32'h0F) : 8'($urandom));
    end

    // R8: cascade of two controllers
    do_reset();
    m_wr = 1; wr_addr = 2'd0; wr_data = 8'h00; cyc();
    m_wr = 1; wr_addr = 2'd1; wr_data = 8'h08; cyc();
    s_wr = 1; wr_addr = 2'd0; wr_data = 8'h00; cyc();
    s_wr = 1; wr_addr = 2'd1; wr_data = 8'h70; cyc();
    casc_mode = 1;
    m_wr = 1; wr_addr = 2'd3; wr_data = 8'h01; cyc();
    s_irq = 8'h20; cyc();
    chk("R8 slave int", 32'(s_int), 1);
    chk("R8 master int", 32'(m_int), 1);
    m_inta_n = 0; #1;
    chk("R8 casc_ack_no", 32'(m_cack_n), 0);
    cyc();
    chk("R8 master silent", 32'(m_voe), 0);
    chk("R8 slave vec_oe", 32'(s_voe), 1);
    chk("R8 slave vec", 32'(s_vec), 32'h75);
    s_irq = 8'h22; cyc();
    chk("R6 slave nests", 32'(s_int), 1);
    chk("R6 line2 in service", 32'(m_int), 0);
    m_wr = 1; wr_addr = 2'd2; cyc();
    chk("R7 master eoi", 32'(m_int), 1);
    m_inta_n = 0; cyc();
    chk("R8 slave vec line1", 32'(s_vec), 32'h71);
    chk("R8 master silent 2", 32'(m_voe), 0);
    m_irq = 8'h01; cyc();
    chk("R6 master line0 over cascade", 32'(m_int), 1);
    m_inta_n = 0; cyc();
    chk("R5 master vec line0", 32'(m_vec), 32'h08);
    chk("R5 master vec_oe", 32'(m_voe), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule